// File: doc/BRIEF.md
# Three-Sample Input Qualifier with Event Filter

This block cleans up a byte of slow switch inputs from a vehicle lighting controller. It takes one sample of the byte on every strobe of the tick input. A bit is accepted only when the three most recent samples agree. Once a bit is accepted it is held in a debounced state register.

On each tick the block also produces an event byte. An event bit marks an accepted change of that input, and the byte stays valid for exactly one clock cycle after the tick. The edge that counts depends on the input:

- The left-turn, right-turn, hazard and cancel inputs report only their rising edge.
- The brake and engine inputs report both edges.
- Two auxiliary flags record where a cancel request came from: the opposite-direction source and the manual source.
  - They are debounced like every other bit.
  - They never raise events of their own.
  - A cancel event passes only when one of them is set in the debounced state.

Downstream logic uses the state byte for levels and the event byte for one-shot actions.

Top module: `tri_sample_qualifier`

## Requirements
- R1: On every tick the sample history moves by one place. The newest sample is `raw_in`, and the oldest of the three is dropped. A changed input can therefore be accepted no earlier than the third tick that carries it.
- R2: A bit whose three samples (the current `raw_in` and the two previous tick samples) do not all agree is unstable. Its debounced value is kept, and it raises no event.
- R3: A stable bit whose value differs from the held debounced value takes the new value in `deb_state`. It is flagged as a raw change in the same tick.
- R4: Bit 0 (left), bit 1 (right), bit 4 (hazard) and bit 5 (cancel) raise an event only on a 0-to-1 change of the debounced value. A 1-to-0 change raises none.
- R5: Bit 2 (brake) and bit 3 (engine) raise an event on both debounced edges.
- R6: A cancel event on bit 5 is suppressed unless bit 6 (opposite-direction flag) or bit 7 (manual flag) is 1 in the debounced state produced by the same tick.
- R7: Bits 6 and 7 of `event_out` are always 0.
- R8: `event_out` holds the events of a tick for exactly the one cycle after that tick's clock edge. It is zero in every other cycle.
- R9: Reset clears the debounced state, the event byte and the two stored history stages. After reset, an input that is held at 1 produces its first event on the third tick.
- R10: Without a tick, changes of `raw_in` have no effect, and `deb_state` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Sample strobe, one cycle wide |
| raw_in | input | 8 | Logical input byte, sampled on tick |
| deb_state | output | 8 | Debounced input state |
| event_out | output | 8 | Filtered change events, valid for one cycle after a tick |

## Verification
In a single tick, the cancel bit and its auxiliary flags can become stable together. In that case the gate must use the flag values accepted in that same tick, not the older ones. The bench provokes this by holding 0x60 for three ticks from a cleared state. It expects the cancel event (0x20) in the cycle after the third tick, with both the auxiliary bit and the bare-cancel case (0x20 alone gives no event) judged at the ports. The exhaustive sweep also lands brake and engine trailing edges in the same tick as leading edges on the turn bits. Each tick is compared bit group by bit group against an arithmetic model.

// File: rtl/tsq_pkg.sv
package tsq_pkg;

   // Default byte layout of the qualifier
   localparam int unsigned DEF_WIDTH      = 8;
   localparam int unsigned DEF_STAGES     = 3;
   localparam int unsigned DEF_LEFT_POS   = 0;
   localparam int unsigned DEF_RIGHT_POS  = 1;
   localparam int unsigned DEF_BRAKE_POS  = 2;
   localparam int unsigned DEF_ENGINE_POS = 3;
   localparam int unsigned DEF_HAZARD_POS = 4;
   localparam int unsigned DEF_CANCEL_POS = 5;
   localparam int unsigned DEF_OPP_POS    = 6;
   localparam int unsigned DEF_MAN_POS    = 7;

   // Single bit mask helper, wide enough for any practical width
   function automatic logic [63:0] one_hot(input int unsigned pos);
      return 64'(1) << pos;
   endfunction

endpackage

// File: rtl/tsq_sample_chain.sv
module tsq_sample_chain #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 3
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               tick,
   input  logic [WIDTH-1:0]                   raw_in,
   output logic [STAGES-1:0][WIDTH-1:0]       view
);

   localparam int unsigned STORED = STAGES - 1;

   logic [STORED-1:0][WIDTH-1:0] hist;

   // Stage 0 is the live sample; older stages are stored
   assign view[0] = raw_in;

   for (genvar k = 0; k < STORED; k++) begin : g_stage
      assign view[k+1] = hist[k];
      if (k == 0) begin : g_head
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    hist[k] <= '0;
            else if (tick) hist[k] <= raw_in;
         end
      end else begin : g_body
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    hist[k] <= '0;
            else if (tick) hist[k] <= hist[k-1];
         end
      end
   end

   // R1
   chain_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> (hist[0] == $past(raw_in)));

endmodule

// File: rtl/tsq_stability_judge.sv
module tsq_stability_judge #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 3
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         tick,
   input  logic [STAGES-1:0][WIDTH-1:0] view,
   output logic [WIDTH-1:0]             state,
   output logic [WIDTH-1:0]             next_state,
   output logic [WIDTH-1:0]             raw_toggle
);

   localparam int unsigned PAIRS = STAGES - 1;

   logic [PAIRS:0][WIDTH-1:0] agree_acc;
   logic [WIDTH-1:0]          stable;

   // Accumulate agreement of each adjacent stage pair
   assign agree_acc[0] = '1;
   for (genvar p = 0; p < PAIRS; p++) begin : g_pair
      assign agree_acc[p+1] = agree_acc[p] & ~(view[p] ^ view[p+1]);
   end
   assign stable = agree_acc[PAIRS];

   always_comb begin
      raw_toggle = stable & (view[0] ^ state);
      next_state = (state & ~stable) | (view[0] & stable);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    state <= '0;
      else if (tick) state <= next_state;
   end

   // R10
   hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(state));

   // R2
   unstable_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> ((($past(view[0]) ^ $past(view[1])) & (state ^ $past(state))) == '0));

endmodule

// File: rtl/tsq_event_qualifier.sv
module tsq_event_qualifier #(
   parameter int unsigned WIDTH        = 8,
   parameter logic [WIDTH-1:0] BOTH_MASK = '0,
   parameter logic [WIDTH-1:0] AUX_MASK  = '0,
   parameter int unsigned CANCEL_POS   = 5,
   parameter int unsigned OPP_POS      = 6,
   parameter int unsigned MAN_POS      = 7,
   parameter bit          CANCEL_GATED = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [WIDTH-1:0] raw_toggle,
   input  logic [WIDTH-1:0] next_state,
   output logic [WIDTH-1:0] event_out
);

   logic [WIDTH-1:0] edge_kept;
   logic [WIDTH-1:0] qualified;

   // Trailing edges survive only on both-edge bits; aux bits never pass
   assign edge_kept = raw_toggle & (next_state | BOTH_MASK) & ~AUX_MASK;

   if (CANCEL_GATED) begin : g_gate
      always_comb begin
         qualified = edge_kept;
         if (!(next_state[OPP_POS] || next_state[MAN_POS]))
            qualified[CANCEL_POS] = 1'b0;
      end
   end else begin : g_nogate
      assign qualified = edge_kept;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) event_out <= '0;
      else        event_out <= tick ? qualified : '0;
   end

   // R8
   quiet_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> (event_out == '0));

endmodule

// File: rtl/tri_sample_qualifier.sv
module tri_sample_qualifier
   import tsq_pkg::*;
#(
   parameter int unsigned WIDTH      = DEF_WIDTH,
   parameter int unsigned STAGES     = DEF_STAGES,
   parameter int unsigned LEFT_POS   = DEF_LEFT_POS,
   parameter int unsigned RIGHT_POS  = DEF_RIGHT_POS,
   parameter int unsigned BRAKE_POS  = DEF_BRAKE_POS,
   parameter int unsigned ENGINE_POS = DEF_ENGINE_POS,
   parameter int unsigned HAZARD_POS = DEF_HAZARD_POS,
   parameter int unsigned CANCEL_POS = DEF_CANCEL_POS,
   parameter int unsigned OPP_POS    = DEF_OPP_POS,
   parameter int unsigned MAN_POS    = DEF_MAN_POS
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [7:0]       raw_in,
   output logic [7:0]       deb_state,
   output logic [7:0]       event_out
);

   localparam logic [WIDTH-1:0] BOTH_MASK =
      WIDTH'(one_hot(BRAKE_POS) | one_hot(ENGINE_POS));
   localparam logic [WIDTH-1:0] AUX_MASK  =
      WIDTH'(one_hot(OPP_POS) | one_hot(MAN_POS));
   localparam logic [WIDTH-1:0] LEAD_MASK =
      WIDTH'(one_hot(LEFT_POS) | one_hot(RIGHT_POS) |
             one_hot(HAZARD_POS) | one_hot(CANCEL_POS));

   // Elaboration-time parameter checks
   if (WIDTH != 8) begin : g_bad_width
      $error("tri_sample_qualifier: port byte requires WIDTH of 8");
   end
   if (STAGES < 2) begin : g_bad_stages
      $error("tri_sample_qualifier: STAGES must be at least 2");
   end
   if (OPP_POS == MAN_POS) begin : g_bad_aux
      $error("tri_sample_qualifier: auxiliary flags must differ");
   end

   logic [STAGES-1:0][WIDTH-1:0] view;
   logic [WIDTH-1:0]             next_state;
   logic [WIDTH-1:0]             raw_toggle;

   tsq_sample_chain #(.WIDTH(WIDTH), .STAGES(STAGES)) i_chain (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick),
      .raw_in (raw_in),
      .view   (view)
   );

   tsq_stability_judge #(.WIDTH(WIDTH), .STAGES(STAGES)) i_judge (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .view       (view),
      .state      (deb_state),
      .next_state (next_state),
      .raw_toggle (raw_toggle)
   );

   tsq_event_qualifier #(
      .WIDTH        (WIDTH),
      .BOTH_MASK    (BOTH_MASK),
      .AUX_MASK     (AUX_MASK),
      .CANCEL_POS   (CANCEL_POS),
      .OPP_POS      (OPP_POS),
      .MAN_POS      (MAN_POS),
      .CANCEL_GATED (1'b1)
   ) i_qual (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .raw_toggle (raw_toggle),
      .next_state (next_state),
      .event_out  (event_out)
   );

   // R4
   lead_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((event_out & LEAD_MASK & ~deb_state) == '0));

   // R5
   brake_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      event_out[BRAKE_POS] |-> (deb_state[BRAKE_POS] != $past(deb_state[BRAKE_POS])));

   // R6
   cancel_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      event_out[CANCEL_POS] |-> (deb_state[OPP_POS] || deb_state[MAN_POS]));

   // R7
   aux_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((event_out & AUX_MASK) == '0));

endmodule

// File: tb/test_tri_sample_qualifier.sv
`timescale 1ns/1ps
module test_tri_sample_qualifier;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic [7:0] raw_in = 8'h00;
   logic [7:0] deb_state;
   logic [7:0] event_out;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // Bench model of the history and the debounced state
   logic [7:0] m0 = 8'h00, m1 = 8'h00, mstate = 8'h00, mev = 8'h00;

   always #4 clk = ~clk;

   tri_sample_qualifier i_tri_sample_qualifier (
      .clk(clk), .rst_n(rst_n), .tick(tick), .raw_in(raw_in),
      .deb_state(deb_state), .event_out(event_out)
   );

   task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
      end
   endtask

   task automatic model_step(input logic [7:0] v);
      logic [7:0] st, rt, ns;
      st = ~((v ^ m0) | (m0 ^ m1));
      rt = st & (v ^ mstate);
      ns = (mstate & ~st) | (v & st);
      mev = rt & (ns | 8'h0C) & 8'h3F;
      if (!(ns[6] | ns[7])) mev[5] = 1'b0;
      mstate = ns;
      m1 = m0;
      m0 = v;
   endtask

   // One tick, then outputs checked in the following low phase, then quiet cycle
   task automatic do_tick(input logic [7:0] v, input bit grouped);
      @(negedge clk);
      raw_in = v;
      tick = 1'b1;
      model_step(v);
      @(negedge clk);
      tick = 1'b0;
      if (grouped) begin
         check8("R3 state", deb_state, mstate);
         check8("R4 lead bits", event_out & 8'h13, mev & 8'h13);
         check8("R5 both-edge bits", event_out & 8'h0C, mev & 8'h0C);
         check8("R6 cancel bit", event_out & 8'h20, mev & 8'h20);
         check8("R7 aux bits", event_out & 8'hC0, 8'h00);
      end
      @(negedge clk);
      if (grouped) check8("R8 quiet cycle", event_out, 8'h00);
   endtask

   task automatic hold3(input logic [7:0] v);
      do_tick(v, 1'b0);
      do_tick(v, 1'b0);
      do_tick(v, 1'b0);
   endtask

   initial begin
      logic [7:0] lcg;
      lcg = 8'h5A;
      repeat (3) @(negedge clk);
      check8("R9 reset state", deb_state, 8'h00);
      check8("R9 reset events", event_out, 8'h00);
      rst_n = 1'b1;

      // R9 / R1: first event on the third tick
      do_tick(8'h0C, 1'b0);
      check8("R1 tick1 no event", event_out, 8'h00);
      do_tick(8'h0C, 1'b0);
      check8("R1 tick2 no event", deb_state, 8'h00);
      @(negedge clk); raw_in = 8'h0C; tick = 1'b1; model_step(8'h0C);
      @(negedge clk); tick = 1'b0;
      check8("R9 third tick event", event_out, 8'h0C);
      check8("R3 third tick state", deb_state, 8'h0C);
      @(negedge clk);
      check8("R8 event one cycle", event_out, 8'h00);

      // R5 trailing edge of brake and engine
      hold3(8'h00);
      check8("R5 trailing state", deb_state, 8'h00);
      @(negedge clk); raw_in = 8'h01; tick = 1'b1; model_step(8'h01);
      @(negedge clk); tick = 1'b0; @(negedge clk);
      hold3(8'h01);
      check8("R4 left state", deb_state, 8'h01);
      // R4 left release gives no event
      do_tick(8'h00, 1'b0); do_tick(8'h00, 1'b0);
      @(negedge clk); raw_in = 8'h00; tick = 1'b1; model_step(8'h00);
      @(negedge clk); tick = 1'b0;
      check8("R4 left release no event", event_out, 8'h00);
      check8("R4 left release state", deb_state, 8'h00);
      @(negedge clk);

      // R6 bare cancel gated off
      do_tick(8'h20, 1'b0); do_tick(8'h20, 1'b0);
      @(negedge clk); raw_in = 8'h20; tick = 1'b1; model_step(8'h20);
      @(negedge clk); tick = 1'b0;
      check8("R6 bare cancel no event", event_out, 8'h00);
      check8("R6 bare cancel state", deb_state, 8'h20);
      @(negedge clk);
      hold3(8'h00);
      // R6/R7 cancel with opposite flag in the same tick
      do_tick(8'h60, 1'b0); do_tick(8'h60, 1'b0);
      @(negedge clk); raw_in = 8'h60; tick = 1'b1; model_step(8'h60);
      @(negedge clk); tick = 1'b0;
      check8("R6 cancel with flag", event_out, 8'h20);
      check8("R7 flag stays silent", event_out & 8'hC0, 8'h00);
      @(negedge clk);

      // R10 raw changes without tick ignored
      for (int i = 0; i < 8; i++) begin
         @(negedge clk); raw_in = 8'(i * 37 + 11);
         @(negedge clk);
         check8("R10 no tick state", deb_state, mstate);
         check8("R10 no tick events", event_out, 8'h00);
      end

      // R2 glitch: one differing sample blocks acceptance
      hold3(8'h00);
      do_tick(8'h04, 1'b1); do_tick(8'h04, 1'b1); do_tick(8'h00, 1'b1);
      check8("R2 glitch keeps state", deb_state, 8'h00);

      // Exhaustive sweep of every byte, with a pseudo-random glitch after
      for (int v = 0; v < 256; v++) begin
         do_tick(8'(v), 1'b1);
         do_tick(8'(v), 1'b1);
         do_tick(8'(v), 1'b1);
         lcg = lcg * 8'd29 + 8'd61;
         do_tick(8'(v) ^ lcg, 1'b1);
      end

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule